// File: doc/BRIEF.md
# Clock Mode Configuration Register

This block stores the three-bit clock configuration of a frequency-synthesis PLL and turns it into the control lines for the surrounding clocking logic. Those lines are PLL enable, bypass or normal output path, and crystal or external reference. Software writes the field through a simple write port and reads it back zero-extended on a wider read bus. The decoded controls come from registers, so they change cleanly on the clock edge that captures a write.

The reference-select bit takes its reset value from a strap input. That input is sampled for as long as reset is held, so it must be stable for the whole reset period. After reset, the block is in bypass with the PLL running.

The block protects the field. While the normal-mode bit is set, the PLL-enable bit cannot be cleared. This forces an exit from normal mode to pass through bypass-with-PLL-running before the PLL can be turned off. A write that would produce a reserved encoding is dropped entirely. A reserved-code flag is still decoded from the stored field as a guard.

Top module: `clkmode_ctl`

## Requirements
- R1: While `rst_n` is low, the field is loaded with bit 2 = `strap_xtal` and bits [1:0] = 2'b10. After release, `pll_en_o`=1, `path_normal_o`=0, `ref_xtal_o`=strap level and `rsv_err_o`=0.
- R2: When the stored bit 0 is 0, a write whose bits [1:0] are not 2'b01 stores `wr_data` unchanged.
- R3: When the stored bit 0 is 1, a write with bit 1 = 0 keeps bit 1 at 1. Bits 0 and 2 still take the written values.
- R4: A write that would store bits [1:0] = 2'b01 (reserved) is ignored completely, including bit 2.
- R5: `pll_en_o` equals field bit 1 (1 = PLL running).
- R6: `path_normal_o` is 1 exactly when field bits [1:0] = 2'b11. Otherwise the path is bypass.
- R7: `ref_xtal_o` equals field bit 2 (1 = crystal, 0 = external).
- R8: `rsv_err_o` is 1 exactly when the field holds bits [1:0] = 2'b01. Under the write rules it stays 0.
- R9: Field and decoded outputs change only on a clock edge with `wr_en` high. The new values are visible right after that edge.
- R10: `rd_data` returns the field in bits [2:0], with every higher bit reading 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| strap_xtal | input | 1 | Strap level giving the reset value of the reference select |
| wr_en | input | 1 | Write strobe for the field |
| wr_data | input | 3 | Field value to write |
| rd_data | output | RD_W | Field readback, zero-extended |
| pll_en_o | output | 1 | PLL enable |
| path_normal_o | output | 1 | 1 = normal (PLL) path, 0 = bypass |
| ref_xtal_o | output | 1 | 1 = crystal reference, 0 = external |
| rsv_err_o | output | 1 | Field holds a reserved encoding |

## Verification
Two resets, one with each strap level, separate the strap-driven bit from the fixed reset bits. Write sequences walk the field from bypass into normal mode and back. These runs separate a plain store from a store where bit 1 is kept by the protection rule, and show that the exit from normal mode must pass through bypass-with-PLL-running. Writes aimed at both reserved codes, including one that also flips bit 2, show that a blocked write leaves every bit unchanged. Cycles with the strobe low and changing data show that the outputs hold.

// File: rtl/clkmode_pkg.sv
package clkmode_pkg;
    localparam int FIELD_W = 3;

    typedef logic [FIELD_W-1:0] field_t;

    typedef struct packed {
        logic pll_en;
        logic path_normal;
        logic ref_xtal;
        logic rsv_err;
    } dec_t;

    typedef struct packed {
        field_t field;
        dec_t   dec;
    } state_t;
endpackage

// File: rtl/clkmode_wrmask.sv
module clkmode_wrmask
    import clkmode_pkg::*;
(
    input  field_t cur_i,
    input  field_t wr_i,
    output field_t nxt_o
);
    field_t masked;

    always_comb begin
        masked = wr_i;
        // bit 1 may not drop while bit 0 is currently set
        if (cur_i[0] && !wr_i[1]) begin
            masked[1] = 1'b1;
        end
        // a write landing on the reserved code is discarded whole
        if (masked[1:0] == 2'b01) begin
            nxt_o = cur_i;
        end else begin
            nxt_o = masked;
        end
    end
endmodule

// File: rtl/clkmode_decode.sv
module clkmode_decode
    import clkmode_pkg::*;
(
    input  field_t field_i,
    output dec_t   dec_o
);
    always_comb begin
        dec_o.pll_en      = field_i[1];
        dec_o.path_normal = field_i[1] & field_i[0];
        dec_o.ref_xtal    = field_i[2];
        dec_o.rsv_err     = field_i[0] & ~field_i[1];
    end
endmodule

// File: rtl/clkmode_ctl.sv
module clkmode_ctl
    import clkmode_pkg::*;
#(
    parameter int RD_W = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 strap_xtal,
    input  logic                 wr_en,
    input  logic [FIELD_W-1:0]   wr_data,
    output logic [RD_W-1:0]      rd_data,
    output logic                 pll_en_o,
    output logic                 path_normal_o,
    output logic                 ref_xtal_o,
    output logic                 rsv_err_o
);
    localparam int PAD_W = RD_W - FIELD_W;

    state_t st_d, st_q;
    field_t masked_nx;
    dec_t   dec_nx;

    clkmode_wrmask u_wrmask (
        .cur_i (st_q.field),
        .wr_i  (wr_data),
        .nxt_o (masked_nx)
    );

    clkmode_decode u_decode (
        .field_i (st_d.field),
        .dec_o   (dec_nx)
    );

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            st_d.field = masked_nx;
        end
        st_d.dec = dec_nx;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.field <= {strap_xtal, 2'b10};
            st_q.dec   <= '{pll_en: 1'b1, path_normal: 1'b0,
                            ref_xtal: strap_xtal, rsv_err: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    generate
        if (PAD_W > 0) begin : g_pad
            assign rd_data = {{PAD_W{1'b0}}, st_q.field};
        end else begin : g_nopad
            assign rd_data = st_q.field[RD_W-1:0];
        end
    endgenerate

    assign pll_en_o      = st_q.dec.pll_en;
    assign path_normal_o = st_q.dec.path_normal;
    assign ref_xtal_o    = st_q.dec.ref_xtal;
    assign rsv_err_o     = st_q.dec.rsv_err;

    // R1: reset loads bypass-with-PLL-running and the strap level
    a_r1_reset_value: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (st_q.field[1:0] == 2'b10 && pll_en_o && !path_normal_o))
        else $error("R1 reset value");

    // R3: bit 1 is kept while bit 0 is set
    a_r3_bit1_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && st_q.field[0]) |=> st_q.field[1])
        else $error("R3 bit 1 cleared");

    // R4 / R8: the stored field never holds the reserved code
    a_r4_no_reserved: assert property (@(posedge clk) disable iff (!rst_n)
        !(st_q.field[1:0] == 2'b01) && !rsv_err_o)
        else $error("R4 reserved stored");

    // R9: without a write, field and outputs hold
    a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> ($stable(st_q.field) && $stable(path_normal_o) && $stable(ref_xtal_o)))
        else $error("R9 hold");

    // R6: registered normal-path output matches the stored field
    a_r6_normal_path: assert property (@(posedge clk) disable iff (!rst_n)
        path_normal_o == (rd_data[1:0] == 2'b11))
        else $error("R6 path decode");

    // R5 / R7: enable and reference outputs track the stored field
    a_r5_r7_track: assert property (@(posedge clk) disable iff (!rst_n)
        (pll_en_o == rd_data[1]) && (ref_xtal_o == rd_data[2]))
        else $error("R5 R7 decode");
endmodule

// File: tb/clkmode_ctl_test.sv
module clkmode_ctl_test;
    localparam int RD_W = 8;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            strap_xtal = 1'b0;
    logic            wr_en = 1'b0;
    logic [2:0]      wr_data = 3'b000;
    logic [RD_W-1:0] rd_data;
    logic            pll_en_o, path_normal_o, ref_xtal_o, rsv_err_o;

    int n_chk = 0;
    int n_bad = 0;
    logic [2:0] exp_f;

    always #2.5 clk = ~clk;

    clkmode_ctl #(.RD_W(RD_W)) uut (
        .clk(clk), .rst_n(rst_n), .strap_xtal(strap_xtal),
        .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
        .pll_en_o(pll_en_o), .path_normal_o(path_normal_o),
        .ref_xtal_o(ref_xtal_o), .rsv_err_o(rsv_err_o)
    );

    function automatic logic [2:0] model_next(logic [2:0] cur, logic [2:0] w);
        logic [2:0] n;
        n = w;
        if (cur[0] && !n[1]) n[1] = 1'b1;
        if (n[1:0] == 2'b01) return cur;
        return n;
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic check_all(string tag);
        check({tag, " R10 rd_data"}, 32'(rd_data), {29'd0, exp_f});
        check({tag, " R5 pll_en"}, 32'(pll_en_o), 32'(exp_f[1]));
        check({tag, " R6 path_normal"}, 32'(path_normal_o), 32'(exp_f[1] & exp_f[0]));
        check({tag, " R7 ref_xtal"}, 32'(ref_xtal_o), 32'(exp_f[2]));
        check({tag, " R8 rsv_err"}, 32'(rsv_err_o), 32'(exp_f[0] & ~exp_f[1]));
    endtask

    task automatic do_reset(logic strap);
        @(negedge clk);
        rst_n = 1'b0;
        strap_xtal = strap;
        wr_en = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        exp_f = {strap, 2'b10};
        @(negedge clk);
    endtask

    task automatic do_write(logic [2:0] w);
        wr_en = 1'b1;
        wr_data = w;
        exp_f = model_next(exp_f, w);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic t_reset;
        do_reset(1'b0);
        check_all("R1 strap0");
        check("R1 field strap0", 32'(rd_data), 32'h2);
        do_reset(1'b1);
        check_all("R1 strap1");
        check("R1 field strap1", 32'(rd_data), 32'h6);
    endtask

    task automatic t_plain_write;
        do_reset(1'b0);
        do_write(3'b111);
        check("R2 enter normal xtal", 32'(rd_data), 32'h7);
        check_all("R2");
        do_write(3'b110);
        check("R2 plain 110", 32'(rd_data), 32'h6);
        do_write(3'b000);
        check("R2 pll off ext", 32'(rd_data), 32'h0);
        check_all("R2 off");
    endtask

    task automatic t_protect;
        do_reset(1'b0);
        do_write(3'b011);
        check("R2 normal ext", 32'(rd_data), 32'h3);
        do_write(3'b000);
        check("R3 bit1 kept", 32'(rd_data), 32'h2);
        check_all("R3 step1");
        do_write(3'b000);
        check("R3 second write clears", 32'(rd_data), 32'h0);
        do_write(3'b111);
        do_write(3'b101);
        check("R3 keep with bit0 write", 32'(rd_data), 32'h7);
        do_write(3'b100);
        check("R3 bit1 kept to bypass", 32'(rd_data), 32'h6);
        check_all("R3 step2");
    endtask

    task automatic t_reserved;
        do_reset(1'b1);
        do_write(3'b000);
        check("R4 setup", 32'(rd_data), 32'h0);
        do_write(3'b101);
        check("R4 blocked incl bit2", 32'(rd_data), 32'h0);
        check("R8 no error", 32'(rsv_err_o), 32'h0);
        do_write(3'b001);
        check("R4 blocked 001", 32'(rd_data), 32'h0);
        check_all("R4");
    endtask

    task automatic t_hold;
        do_reset(1'b0);
        do_write(3'b111);
        wr_data = 3'b000;
        @(negedge clk);
        check("R9 hold data0", 32'(rd_data), 32'h7);
        wr_data = 3'b010;
        @(negedge clk);
        check_all("R9 hold");
    endtask

    initial begin
        fork
            begin
                t_reset();
                t_plain_write();
                t_protect();
                t_reserved();
                t_hold();
            end
            begin
                repeat (5000) @(posedge clk);
                n_chk++;
                n_bad++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        disable fork;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule